// File: doc/BRIEF.md
# Burst Address and Transfer Sequencer

This block sits on the master side of a pipelined system bus. A local client hands it one burst command: a start address, a beat-count code, a mode bit that selects incrementing or wrapping order, and a transfer size. The sequencer then drives the address and the 2-bit transfer type for every bus cycle until the burst is finished. The first beat is marked as a non-sequential transfer. Every later beat is marked sequential. After the last beat the bus returns to idle.

Every output is registered. The outputs move only on clock edges where the bus signals ready, so slave wait states stretch the current phase without disturbing it. When the local side asks for a stall just as the sequencer is about to present a new beat, it shows a BUSY cycle instead. That BUSY cycle already carries the pending address, but it does not count as a beat. In wrapping mode the address folds back inside an aligned window whose size in bytes is the beat count times the transfer size.

Top module: `burst_seq`

## Requirements
- R1: Synchronous active-high reset leaves `bus_trans` at IDLE (2'b00) and `cmd_ready` high.
- R2: Transfer type encoding is IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10, SEQ=2'b11. The first beat of a burst is NONSEQ and each later beat is SEQ.
- R3: With `cmd_wrap`=0, beat k is presented at start + k*step and never folds back, even when it crosses an aligned boundary.
- R4: With `cmd_wrap`=1, beat k is presented at (start & ~(span-1)) | ((start + k*step) & (span-1)), where span = beats*step. Example: 4 word beats from 0x38 give 0x38, 0x3C, 0x30, 0x34.
- R5: On a rising edge where `bus_ready` is low, `bus_addr`, `bus_trans` and `bus_size` keep their values.
- R6: A beat completes on a ready edge that shows NONSEQ or SEQ. If `local_stall` is high on that edge and beats remain, the next cycle is BUSY with the next beat's address. BUSY repeats while the stall stays high on ready edges. It turns into SEQ, with the same address, on the first ready edge without a stall. BUSY cycles are not counted as beats.
- R7: When the final beat completes on a ready edge, the next cycle is IDLE and `cmd_ready` is high. A single-beat burst therefore shows one NONSEQ cycle and then IDLE.
- R8: `cmd_len` codes 0, 1, 2, 3 select 1, 4, 8, 16 beats. `cmd_size` codes 0, 1, 2 select 1, 2, 4 bytes, and code 3 is treated as 4 bytes. The address step equals the size in bytes. `bus_size` repeats the latched size code for the whole burst.
- R9: A command is taken only on an edge where `cmd_valid`, `cmd_ready` and `bus_ready` are all high. `cmd_ready` is low for the whole burst, and changes to the command inputs during a burst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Burst command present |
| cmd_ready | output | 1 | Sequencer is idle and can take a command |
| cmd_addr | input | AW | Start address of the burst |
| cmd_len | input | 2 | Beat-count code (1/4/8/16) |
| cmd_wrap | input | 1 | 1 = wrapping order, 0 = incrementing |
| cmd_size | input | 2 | Transfer size code (byte/halfword/word) |
| local_stall | input | 1 | Local side cannot supply the next beat yet |
| bus_ready | input | 1 | Bus ready; low stretches the current phase |
| bus_addr | output | AW | Address phase output |
| bus_trans | output | 2 | Transfer type |
| bus_size | output | 2 | Size code of the running burst |

## Verification
A corrupted remaining-beat counter shows up at the end of the burst. The bus either goes to IDLE one or more beats early, or keeps issuing SEQ beats past the last one. This is visible within a beat of the expected end. A wrong latched window mask or step shows on the very next SEQ address, and it is clearest on a wrapping burst that starts near the top of its window. A transfer-type state that ignores `bus_ready` or `local_stall` shows in the following cycle as a changed address or type during a wait state, or as a SEQ beat where BUSY was due.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  // beat-count code to number of beats
  function automatic logic [4:0] beats_of(input logic [1:0] len_code);
    case (len_code)
      2'd0:    beats_of = 5'd1;
      2'd1:    beats_of = 5'd4;
      2'd2:    beats_of = 5'd8;
      default: beats_of = 5'd16;
    endcase
  endfunction

  // size code to log2 of bytes; the reserved code behaves as a word
  function automatic logic [1:0] shift_of(input logic [1:0] size_code);
    shift_of = (size_code == 2'd3) ? 2'd2 : size_code;
  endfunction

endpackage

// File: rtl/burst_addr_next.sv
module burst_addr_next #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    shamt,
  input  logic [AW-1:0] win_mask,
  input  logic          wrap_en,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;
  logic [AW-1:0] bumped;

  always_comb begin
    step   = AW'(1) << shamt;
    bumped = cur + step;
    if (wrap_en) nxt = (cur & ~win_mask) | (bumped & win_mask);
    else         nxt = bumped;
  end
endmodule

// File: rtl/burst_beat_count.sv
module burst_beat_count #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - CW'(1);
  end

  assign last = (left_q == '0);
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW        = 32,
  parameter int MAX_BEATS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [1:0]    cmd_len,
  input  logic          cmd_wrap,
  input  logic [1:0]    cmd_size,
  input  logic          local_stall,
  input  logic          bus_ready,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_trans,
  output logic [1:0]    bus_size
);
  import burst_seq_pkg::*;

  localparam int CW = $clog2(MAX_BEATS) + 1;

  trans_e        trans_q;
  logic          active_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] mask_q;
  logic [AW-1:0] addr_nxt;
  logic [1:0]    sh_q;
  logic [1:0]    size_q;
  logic          wrap_q;
  logic          on_last;

  logic take_cmd;
  logic beat_done;
  logic advance;
  logic busy_edge;

  assign take_cmd  = bus_ready & ~active_q & cmd_valid;
  assign beat_done = bus_ready & active_q &
                     ((trans_q == TR_NSEQ) | (trans_q == TR_SEQ));
  assign advance   = beat_done & ~on_last;
  assign busy_edge = bus_ready & active_q & (trans_q == TR_BUSY);

  burst_beat_count #(.CW(CW)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .load     (take_cmd),
    .load_val (CW'(beats_of(cmd_len)) - CW'(1)),
    .dec      (advance),
    .last     (on_last)
  );

  burst_addr_next #(.AW(AW)) nxt_i (
    .cur      (addr_q),
    .shamt    (sh_q),
    .win_mask (mask_q),
    .wrap_en  (wrap_q),
    .nxt      (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      trans_q  <= TR_IDLE;
      addr_q   <= '0;
      mask_q   <= '0;
      sh_q     <= 2'd0;
      size_q   <= 2'd0;
      wrap_q   <= 1'b0;
    end else if (take_cmd) begin
      active_q <= 1'b1;
      trans_q  <= TR_NSEQ;
      addr_q   <= cmd_addr;
      size_q   <= cmd_size;
      sh_q     <= shift_of(cmd_size);
      wrap_q   <= cmd_wrap;
      mask_q   <= (AW'(beats_of(cmd_len)) << shift_of(cmd_size)) - AW'(1);
    end else if (beat_done) begin
      if (on_last) begin
        active_q <= 1'b0;
        trans_q  <= TR_IDLE;
      end else begin
        addr_q  <= addr_nxt;
        trans_q <= local_stall ? TR_BUSY : TR_SEQ;
      end
    end else if (busy_edge) begin
      trans_q <= local_stall ? TR_BUSY : TR_SEQ;
    end
  end

  assign cmd_ready = ~active_q;
  assign bus_addr  = addr_q;
  assign bus_trans = trans_q;
  assign bus_size  = size_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_trans,
  input logic [1:0]    bus_size
);
  assert_hold_on_wait_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |=> $stable(bus_addr) && $stable(bus_trans) && $stable(bus_size));

  assert_first_beat_nonseq_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && bus_ready |=> bus_trans == 2'b10);

  assert_idle_stays_idle_R2: assert property (@(posedge clk) disable iff (rst)
    bus_trans == 2'b00 && !(cmd_valid && bus_ready) |=> bus_trans == 2'b00);

  assert_busy_resolves_R6: assert property (@(posedge clk) disable iff (rst)
    bus_trans == 2'b01 && bus_ready |=>
      (bus_trans == 2'b01 || bus_trans == 2'b11) && $stable(bus_addr));

  assert_ready_only_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> bus_trans == 2'b00);

  assert_idle_gives_ready_R9: assert property (@(posedge clk) disable iff (rst)
    bus_trans == 2'b00 |-> cmd_ready);

  assert_size_steady_R8: assert property (@(posedge clk) disable iff (rst)
    bus_trans == 2'b11 || bus_trans == 2'b01 |-> $stable(bus_size));
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_trans (bus_trans),
  .bus_size  (bus_size)
);

// File: tb/burst_seq_tb_top.sv
`timescale 1ns/1ps
module burst_seq_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [1:0]    cmd_len = 2'd0;
  logic          cmd_wrap = 1'b0;
  logic [1:0]    cmd_size = 2'd0;
  logic          local_stall = 1'b0;
  logic          bus_ready = 1'b1;
  logic          cmd_ready;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_trans;
  logic [1:0]    bus_size;

  burst_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wrap(cmd_wrap),
    .cmd_size(cmd_size), .local_stall(local_stall), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_size(bus_size)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference state
  bit            m_act = 1'b0;
  logic [1:0]    m_trans = 2'b00;
  int            m_rem = 0;
  int            m_beat = 0;
  logic [AW-1:0] s_addr = '0;
  logic [1:0]    s_len = 2'd0;
  logic [1:0]    s_size = 2'd0;
  bit            s_wrap = 1'b0;
  bit            taken = 1'b0;
  logic [AW-1:0] cap [16];
  int            ncap = 0;

  function automatic int beats_f(logic [1:0] ln);
    return (ln == 2'd0) ? 1 : (ln == 2'd1) ? 4 : (ln == 2'd2) ? 8 : 16;
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] st, int k, bit w,
                                             logic [1:0] sz, logic [1:0] ln);
    int stp;
    logic [AW-1:0] span;
    logic [AW-1:0] off;
    stp  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    span = AW'(beats_f(ln) * stp);
    off  = st + AW'(k * stp);
    return w ? ((st & ~(span - 1)) | (off & (span - 1))) : off;
  endfunction

  task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_act = 1'b0; m_trans = 2'b00;
    end else if (bus_ready) begin
      if (!m_act) begin
        if (cmd_valid) begin
          m_act = 1'b1; m_trans = 2'b10; m_beat = 0;
          m_rem = beats_f(s_len) - 1; taken = 1'b1;
        end
      end else if (m_trans == 2'b10 || m_trans == 2'b11) begin
        if (m_rem == 0) begin
          m_act = 1'b0; m_trans = 2'b00;
        end else begin
          m_rem--; m_beat++;
          m_trans = local_stall ? 2'b01 : 2'b11;
        end
      end else if (m_trans == 2'b01) begin
        m_trans = local_stall ? 2'b01 : 2'b11;
      end
    end
  endtask

  task automatic check_outputs();
    chk(bus_trans == m_trans, "R2 R6 R7 transfer type", AW'(bus_trans), AW'(m_trans));
    chk(cmd_ready == !m_act, "R9 cmd_ready", AW'(cmd_ready), AW'(!m_act));
    if (m_act) begin
      chk(bus_addr == exp_addr(s_addr, m_beat, s_wrap, s_size, s_len),
          s_wrap ? "R4 wrap address" : "R3 incr address",
          bus_addr, exp_addr(s_addr, m_beat, s_wrap, s_size, s_len));
      chk(bus_size == s_size, "R8 bus_size", AW'(bus_size), AW'(s_size));
    end
  endtask

  task automatic cycle(bit rnd, bit scramble);
    bus_ready   = rnd ? ($urandom % 4 != 0) : 1'b1;
    local_stall = rnd ? ($urandom % 3 == 0) : 1'b0;
    if (scramble && taken) begin
      cmd_addr = $urandom; cmd_len = 2'($urandom); cmd_size = 2'($urandom);
      cmd_wrap = 1'($urandom);
    end
    if ((bus_trans == 2'b10 || bus_trans == 2'b11) && bus_ready && ncap < 16) begin
      cap[ncap] = bus_addr;
      ncap++;
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (taken) cmd_valid = 1'b0;
    check_outputs();
  endtask

  task automatic run_burst(logic [AW-1:0] a, logic [1:0] ln, logic [1:0] sz,
                           bit w, bit rnd, bit scramble);
    int guard;
    cmd_addr = a; cmd_len = ln; cmd_size = sz; cmd_wrap = w;
    s_addr = a; s_len = ln; s_size = sz; s_wrap = w;
    cmd_valid = 1'b1; taken = 1'b0; ncap = 0; guard = 0;
    do begin
      cycle(rnd, scramble);
      guard++;
    end while (!(taken && !m_act) && guard < 2000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_trans == 2'b00, "R1 reset trans", AW'(bus_trans), AW'(0));
    chk(cmd_ready == 1'b1, "R1 reset cmd_ready", AW'(cmd_ready), AW'(1));
    rst = 1'b0;
    @(posedge clk); model_step(); @(negedge clk);

    // R4 wrap example
    run_burst(32'h38, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0);
    chk(ncap == 4, "R4 beat count", AW'(ncap), AW'(4));
    chk(cap[0] == 32'h38, "R4 beat0", cap[0], 32'h38);
    chk(cap[1] == 32'h3C, "R4 beat1", cap[1], 32'h3C);
    chk(cap[2] == 32'h30, "R4 beat2", cap[2], 32'h30);
    chk(cap[3] == 32'h34, "R4 beat3", cap[3], 32'h34);

    // R3 incrementing across a boundary
    run_burst(32'h3C, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0);
    chk(cap[1] == 32'h40, "R3 no wrap", cap[1], 32'h40);
    chk(cap[3] == 32'h48, "R3 last beat", cap[3], 32'h48);

    // R7 single beat
    run_burst(32'h1234, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0);
    chk(ncap == 1, "R7 single beat", AW'(ncap), AW'(1));

    // R4 halfword wrap8 near top of window
    run_burst(32'h0E, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0);
    chk(cap[1] == 32'h00, "R4 halfword fold", cap[1], 32'h00);
    chk(ncap == 8, "R8 eight beats", AW'(ncap), AW'(8));

    // R8 reserved size code behaves as word; sixteen byte beats wrap
    run_burst(32'h100, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0);
    chk(cap[3] == 32'h10C, "R8 size code 3", cap[3], 32'h10C);
    run_burst(32'h1F3, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0);
    chk(ncap == 16, "R8 sixteen beats", AW'(ncap), AW'(16));
    chk(cap[13] == 32'h1F0, "R4 byte fold", cap[13], 32'h1F0);

    // R5 R6 R9 random waits, stalls and command scrambling
    for (int i = 0; i < 400; i++) begin
      run_burst($urandom, 2'($urandom), 2'($urandom % 3), 1'($urandom), 1'b1, 1'(i % 2));
      if ($urandom % 4 == 0) begin
        bus_ready = 1'b0;
        @(posedge clk); model_step(); @(negedge clk); check_outputs();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule